// File: doc/BRIEF.md
# CAN Controller Configuration-Mode Sequencer

This block sequences the reset and configuration mode of a CAN controller. After a hardware reset the controller is held in configuration mode. A reset-event interrupt flag is raised at the same time, and that flag is raised again whenever the controller wakes from standby. While the controller is in configuration mode, software programs the bit-timing word and the mailbox configuration word through a small register port. It then drops the configuration request.

Once the request is dropped, the sequencer searches the bus for idle. It counts consecutive recessive bits, one per bit-time strobe. After the programmed run length it leaves configuration mode and enables bus participation. Software can send the controller back to configuration mode at any time by setting the request again.

Top module: `can_cfg_sequencer`

## Requirements
- R1: After reset, register reads return the following values. CTRL (address 0) bit0 = 1 (configuration request). STATUS (address 1) reads 1: bit0 = in-configuration is 1 and bit1 = on-bus is 0. IFLAG (address 2) bit0 = 1. IMASK (address 3) bit0 = 1, meaning masked. BTIME (address 4) and MBCFG (address 5) read 0. `irq_o` is 0.
- R2: A one-cycle pulse on `wake_i` sets the IFLAG bit0 reset-event flag.
- R3: `irq_o` is high whenever the IFLAG bit0 flag is set and the IMASK bit0 mask is clear. It rises as soon as the mask is cleared while the flag is pending.
- R4: Writes to BTIME or MBCFG take effect only while STATUS bit0 is 1. At any other time they are ignored, and the register keeps its value.
- R5: With CTRL bit0 at 0 and the controller in configuration mode, the controller leaves configuration mode after IDLE_BITS consecutive strobed recessive bits (IDLE_BITS defaults to 11, and recessive is `rx_bit_i` = 1). Leaving sets STATUS to 2: bit0 = 0 and bit1 = 1.
- R6: A strobed dominant bit during the idle search restarts the recessive count from zero.
- R7: Writing 1 to IFLAG bit0 clears the flag. Writing 0 leaves it unchanged.
- R8: Writing 1 to CTRL bit0 while on the bus returns the controller to configuration mode. STATUS reads 1 on the next clock.
- R9: Recessive samples without `bit_tick_i` do not advance the idle count.
- R10: Status, flag and interrupt outputs are registered. Each is visible one clock after the write or bit that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous hardware reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | DATA_W | Write data |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | DATA_W | Read data (combinational from registered state) |
| wake_i | input | 1 | Standby-recovery pulse |
| rx_bit_i | input | 1 | Sampled bus bit, 1 = recessive |
| bit_tick_i | input | 1 | One-cycle strobe per bit time |
| irq_o | output | 1 | Reset-event interrupt |
| cfg_mode_o | output | 1 | Controller is in configuration mode |
| bus_on_o | output | 1 | Bus communication enabled |

## Verification
The idle search is driven by a sweep that places a single dominant bit after every possible recessive run length from 0 to IDLE_BITS-1. Each case is followed by exactly IDLE_BITS-1 recessive bits and then one more. This tells a counter that restarts on dominant apart from one that merely pauses or ignores dominant, and it also exposes an off-by-one in the exit threshold. Long recessive stretches without strobes separate counting on the strobe from counting on the clock. Configuration-word writes issued both before and after joining the bus show the write lock. Flag writes of 0 and 1, with the mask both set and clear, separate write-one-to-clear from plain write and show that the interrupt follows the mask.

// File: rtl/can_cfg_pkg.sv
package can_cfg_pkg;
   localparam int unsigned REG_AW = 3;
   localparam logic [REG_AW-1:0] A_CTRL   = 3'd0;
   localparam logic [REG_AW-1:0] A_STATUS = 3'd1;
   localparam logic [REG_AW-1:0] A_IFLAG  = 3'd2;
   localparam logic [REG_AW-1:0] A_IMASK  = 3'd3;
   localparam logic [REG_AW-1:0] A_CFG0   = 3'd4;
   typedef enum logic [1:0] {
      ST_CFG    = 2'b01,
      ST_BUS_ON = 2'b10
   } run_state_e;
endpackage

// File: rtl/can_cfg_idle_detect.sv
module can_cfg_idle_detect #(
   parameter int unsigned IDLE_BITS = 11,
   localparam int unsigned CW = $clog2(IDLE_BITS + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic search_i,
   input  logic tick_i,
   input  logic rx_i,
   output logic idle_hit_o
);
   logic [CW-1:0] cnt_q;
   localparam logic [CW-1:0] LAST = CW'(IDLE_BITS - 1);

   assign idle_hit_o = search_i && tick_i && rx_i && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt_q <= '0;
      else if (!search_i)            cnt_q <= '0;
      else if (tick_i) begin
         if (!rx_i || idle_hit_o)    cnt_q <= '0;
         else                        cnt_q <= cnt_q + 1'b1;
      end
   end

   p_dominant_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
      search_i && tick_i && !rx_i |=> cnt_q == '0);
   p_strobe_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
      search_i && !tick_i && $past(search_i) |=> $stable(cnt_q) || cnt_q == '0);
   p_no_overrun_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);
endmodule

// File: rtl/can_cfg_irq.sv
module can_cfg_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   input  logic mask_we_i,
   input  logic mask_d_i,
   output logic flag_o,
   output logic mask_o,
   output logic irq_o
);
   logic flag_d, mask_d;

   always_comb begin
      flag_d = set_i ? 1'b1 : (clr_i ? 1'b0 : flag_o);
      mask_d = mask_we_i ? mask_d_i : mask_o;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_o <= 1'b1;
         mask_o <= 1'b1;
         irq_o  <= 1'b0;
      end else begin
         flag_o <= flag_d;
         mask_o <= mask_d;
         irq_o  <= flag_d & ~mask_d;
      end
   end

   p_irq_when_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> flag_o && !mask_o);
   p_wake_sets_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_o);
   p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i && !set_i |=> !flag_o && !irq_o);
endmodule

// File: rtl/can_cfg_regblk.sv
module can_cfg_regblk #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned NCFG   = 2,
   parameter int unsigned BASE   = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         allow_i,
   input  logic                         wr_en_i,
   input  logic [ADDR_W-1:0]            wr_addr_i,
   input  logic [DATA_W-1:0]            wr_data_i,
   output logic [NCFG-1:0][DATA_W-1:0]  cfg_o
);
   for (genvar g = 0; g < NCFG; g++) begin : g_cfg
      localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(BASE + g);
      logic hit;
      assign hit = wr_en_i && (wr_addr_i == MY_ADDR);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)               cfg_o[g] <= '0;
         else if (hit && allow_i)  cfg_o[g] <= wr_data_i;
      end

      p_cfg_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
         hit && !allow_i |=> $stable(cfg_o[g]));
   end
endmodule

// File: rtl/can_cfg_sequencer.sv
module can_cfg_sequencer #(
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned ADDR_W    = 3,
   parameter int unsigned IDLE_BITS = 11,
   parameter int unsigned NCFG      = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [DATA_W-1:0] rd_data_o,
   input  logic              wake_i,
   input  logic              rx_bit_i,
   input  logic              bit_tick_i,
   output logic              irq_o,
   output logic              cfg_mode_o,
   output logic              bus_on_o
);
   import can_cfg_pkg::*;

   if (IDLE_BITS < 2)                 begin : g_bad_idle  $error("IDLE_BITS must be at least 2");  end
   if (DATA_W < 2)                    begin : g_bad_data  $error("DATA_W must be at least 2");     end
   if (ADDR_W < REG_AW)               begin : g_bad_addr  $error("ADDR_W too narrow for map");     end
   if (NCFG + 4 > (1 << ADDR_W))      begin : g_bad_ncfg  $error("NCFG does not fit address map"); end

   logic                        req_q;
   run_state_e                  st_q;
   logic                        idle_hit, searching;
   logic                        flag, mask;
   logic [NCFG-1:0][DATA_W-1:0] cfg_words;
   logic                        wr_ctrl, wr_flag, wr_mask;

   assign wr_ctrl = wr_en_i && (wr_addr_i == ADDR_W'(A_CTRL));
   assign wr_flag = wr_en_i && (wr_addr_i == ADDR_W'(A_IFLAG));
   assign wr_mask = wr_en_i && (wr_addr_i == ADDR_W'(A_IMASK));

   assign cfg_mode_o = (st_q == ST_CFG);
   assign bus_on_o   = (st_q == ST_BUS_ON);
   assign searching  = cfg_mode_o && !req_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q <= 1'b1;
         st_q  <= ST_CFG;
      end else begin
         if (wr_ctrl) req_q <= wr_data_i[0];
         if (wr_ctrl && wr_data_i[0])  st_q <= ST_CFG;
         else if (idle_hit)            st_q <= ST_BUS_ON;
      end
   end

   can_cfg_idle_detect #(.IDLE_BITS(IDLE_BITS)) i_idle (
      .clk(clk), .rst_n(rst_n), .search_i(searching),
      .tick_i(bit_tick_i), .rx_i(rx_bit_i), .idle_hit_o(idle_hit));

   can_cfg_irq i_irq (
      .clk(clk), .rst_n(rst_n), .set_i(wake_i),
      .clr_i(wr_flag && wr_data_i[0]),
      .mask_we_i(wr_mask), .mask_d_i(wr_data_i[0]),
      .flag_o(flag), .mask_o(mask), .irq_o(irq_o));

   can_cfg_regblk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NCFG(NCFG),
                    .BASE(int'(A_CFG0))) i_regs (
      .clk(clk), .rst_n(rst_n), .allow_i(cfg_mode_o), .wr_en_i(wr_en_i),
      .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .cfg_o(cfg_words));

   always_comb begin
      rd_data_o = '0;
      if (rd_addr_i == ADDR_W'(A_CTRL))        rd_data_o[0]   = req_q;
      else if (rd_addr_i == ADDR_W'(A_STATUS)) rd_data_o[1:0] = st_q;
      else if (rd_addr_i == ADDR_W'(A_IFLAG))  rd_data_o[0]   = flag;
      else if (rd_addr_i == ADDR_W'(A_IMASK))  rd_data_o[0]   = mask;
      else begin
         for (int i = 0; i < int'(NCFG); i++)
            if (rd_addr_i == ADDR_W'(int'(A_CFG0) + i)) rd_data_o = cfg_words[i];
      end
   end

   p_join_on_recessive_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_on_o) |-> $past(bit_tick_i && rx_bit_i && !req_q));
   p_state_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(st_q));
   p_back_to_cfg_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl && wr_data_i[0] |=> cfg_mode_o && !bus_on_o);
   p_hold_while_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
      req_q && cfg_mode_o |=> cfg_mode_o);
endmodule

// File: tb/test_can_cfg_sequencer.sv
module test_can_cfg_sequencer;
   localparam int DW = 16, AW = 3, IDLE = 11;
   logic clk = 1'b0, rst_n = 1'b0;
   logic wr_en = 0, wake = 0, rx = 1, tick = 0;
   logic [AW-1:0] wr_addr = '0, rd_addr = '0;
   logic [DW-1:0] wr_data = '0, rd_data;
   logic irq, cfg_mode, bus_on;
   int n_run = 0, n_fail = 0;

   always #10 clk = ~clk;

   can_cfg_sequencer #(.DATA_W(DW), .ADDR_W(AW), .IDLE_BITS(IDLE)) i_can_cfg_sequencer (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
      .rd_addr_i(rd_addr), .rd_data_o(rd_data), .wake_i(wake), .rx_bit_i(rx),
      .bit_tick_i(tick), .irq_o(irq), .cfg_mode_o(cfg_mode), .bus_on_o(bus_on));

   task automatic chk(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic rd(input int a, input string req, input int exp);
      rd_addr = AW'(a); #1;
      chk(req, int'(rd_data), exp);
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk); wr_en = 1; wr_addr = AW'(a); wr_data = DW'(d);
      @(negedge clk); wr_en = 0;
   endtask

   task automatic bit_t(input logic v);
      @(negedge clk); tick = 1; rx = v;
      @(negedge clk); tick = 0; rx = 1;
   endtask

   initial begin
      #200000000;
      n_fail++;
      $display("FAIL watchdog: got hang expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      rd(0, "R1 ctrl", 1); rd(1, "R1 status", 1); rd(2, "R1 flag", 1);
      rd(3, "R1 mask", 1); rd(4, "R1 btime", 0); rd(5, "R1 mbcfg", 0);
      chk("R1 irq", int'(irq), 0);
      // R7 writing 0 leaves flag
      wr(2, 0); rd(2, "R7 w0 keeps flag", 1);
      // R3 / R10 unmask with flag pending: irq visible one clock after write
      wr(3, 0); chk("R3 irq on unmask", int'(irq), 1); chk("R10 irq timing", int'(irq), 1);
      // R7 W1C
      wr(2, 1); rd(2, "R7 w1 clears", 0); chk("R7 irq drops", int'(irq), 0);
      // R4 writable in config mode
      wr(4, 16'hA5A5); rd(4, "R4 btime cfg", 16'hA5A5);
      wr(5, 16'h3C3C); rd(5, "R4 mbcfg cfg", 16'h3C3C);
      // R9 recessive without strobes does not count
      wr(0, 0);
      rx = 1; repeat (3 * IDLE) @(negedge clk);
      chk("R9 no strobe", int'(cfg_mode), 1);
      // R6/R5 sweep: dominant after k recessive bits
      for (int k = 0; k < IDLE; k++) begin
         wr(0, 1); wr(0, 0);
         for (int j = 0; j < k; j++) bit_t(1);
         bit_t(0);
         for (int j = 0; j < IDLE - 1; j++) bit_t(1);
         chk($sformatf("R6 k=%0d still cfg", k), int'(cfg_mode), 1);
         bit_t(1);
         chk($sformatf("R5 k=%0d joined", k), int'(bus_on), 1);
         rd(1, "R5 status", 2);
      end
      // R4 locked on bus
      wr(4, 16'h00FF); rd(4, "R4 btime locked", 16'hA5A5);
      wr(5, 16'h1111); rd(5, "R4 mbcfg locked", 16'h3C3C);
      // R8 back to config
      wr(0, 1); rd(1, "R8 status", 1); chk("R8 bus off", int'(bus_on), 0);
      // R2 wake sets flag, irq follows (mask clear)
      @(negedge clk); wake = 1; @(negedge clk); wake = 0;
      rd(2, "R2 flag", 1); chk("R2 irq", int'(irq), 1);
      // R3 masking drops irq
      wr(3, 1); chk("R3 masked", int'(irq), 0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule